// File: doc/BRIEF.md
# Flash Multi-Block Erase Sequencer

This block controls erasure of a flash array. The array holds a parameterised number of ordinary blocks, counted across a low, a mid and a high address region, plus one shadow block and one test block. Software drives a small set of register-style strobes. It opens an erase session, picks ordinary blocks through a select mask and protects blocks through an independent lock mask. An interlock write then arms the session, and a start command launches it. The sequencer walks the chosen, unprotected blocks from the lowest index upwards. For every word of each block it issues one write beat carrying all-ones data towards the array. When the walk ends it raises a completion flag and reports the outcome in a success flag.

Block indices are numbered from 0 to NB-1 for the ordinary blocks, where NB = N_LOW + N_MID + N_HIGH. The shadow block has index NB and the test block has index NB+1. Bit NB of the select mask is the test-block select, and bit NB of the lock mask is the shadow-block lock. The erase beats leave on a valid/ready stream. A beat whose `ers_valid` is high stays on the stream, unchanged, until `ers_ready` accepts it. The only exception is an abort, which withdraws the pending beat. The array must treat a withdrawn beat as never written. The control and status pins are plain levels and strobes.

Top module: `erase_seq`

## Requirements
- R1: Every erase beat carries data with all bits set to 1. Each erased block produces exactly WORDS_PER_BLK beats, with word numbers running 0 to WORDS_PER_BLK-1.
- R2: An erase begins only after this sequence: a control write with erase=1, an interlock write, then a control write with erase=1 and start=1. A start issued before the interlock write is ignored.
- R3: A block whose select bit is 1 but whose lock bit is 1 produces no beats.
- R4: The test block (index NB, select bit NB) never produces beats, whatever the select mask holds.
- R5: If the interlock write has `ilk_shadow`=1, only the shadow block (index NB) is erased and the select mask is ignored. If lock bit NB is set, nothing is erased.
- R6: A control write with erase=0 before start ends the session. No beats are issued and `done` stays low.
- R7: A control write with start=0 or erase=0 while an erase runs aborts it. From the next cycle, `done`=1, `good`=0 and `ers_valid`=0.
- R8: Blocks are erased in ascending index order. Each block completes all its words before the next block begins.
- R9: If no block remains after masking, `done`=1 and `good`=1 hold in the cycle right after the start write.
- R10: Writes to the select and lock masks are ignored while an erase runs.
- R11: While `ers_valid`=1 and `ers_ready`=0, the next cycle still shows `ers_valid`=1 with the same block and word, unless an abort was written.
- R12: After reset, `done`, `good` and `ers_valid` are 0, and both masks are 0.
- R13: After completion, `done` stays high until a control write with start=0. With erase=1, that write returns the session to block selection, where a fresh interlock write is needed before the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Control write strobe |
| mode_ers | input | 1 | Erase-session bit of the control write |
| mode_start | input | 1 | Start bit of the control write |
| sel_we | input | 1 | Select mask write strobe |
| sel_data | input | NB+1 | Select mask: bits 0..NB-1 ordinary blocks, bit NB test block |
| lock_we | input | 1 | Lock mask write strobe |
| lock_data | input | NB+1 | Lock mask: bits 0..NB-1 ordinary blocks, bit NB shadow block |
| ilk_we | input | 1 | Interlock write strobe |
| ilk_shadow | input | 1 | Interlock write targets the shadow address space |
| done | output | 1 | Operation complete |
| good | output | 1 | Last operation finished without abort |
| ers_valid | output | 1 | Erase beat valid |
| ers_ready | input | 1 | Array accepts the beat |
| ers_blk | output | clog2(NB+2) | Block index of the beat |
| ers_word | output | clog2(WORDS_PER_BLK) | Word within the block |
| ers_data | output | DATA_W | Data to write (all ones) |

## Verification
The bench builds the block with N_LOW=1, N_MID=2, N_HIGH=3 and WORDS_PER_BLK=3. This gives six ordinary blocks with unequal region sizes, a shadow index of 6 and a test index of 7. Short blocks keep full six-block walks, aborts in the middle of a block, and block-boundary ordering within a few dozen cycles. A throttled ready pattern stalls beats at both word and block boundaries, and mask writes land in the middle of such a walk.

// File: rtl/erase_pkg.sv
package erase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEL  = 3'd1,
    ST_ARM  = 3'd2,
    ST_RUN  = 3'd3,
    ST_DONE = 3'd4
  } ers_state_e;
endpackage

// File: rtl/ers_regs.sv
module ers_regs #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic             sel_we,
  input  logic [NBITS-1:0] sel_data,
  input  logic             lock_we,
  input  logic [NBITS-1:0] lock_data,
  output logic [NBITS-1:0] sel_q,
  output logic [NBITS-1:0] lock_q
);
  // Masks are frozen while a walk is in flight.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      lock_q <= '0;
    end else if (wr_ok) begin
      if (sel_we)  sel_q  <= sel_data;
      if (lock_we) lock_q <= lock_data;
    end
  end
endmodule

// File: rtl/ers_ctrl.sv
module ers_ctrl
  import erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic       mode_ers,
  input  logic       mode_start,
  input  logic       ilk_we,
  input  logic       ilk_shadow,
  input  logic       cand_empty,
  input  logic       run_last,
  output ers_state_e state,
  output logic       shadow_q,
  output logic       load,
  output logic       done,
  output logic       good
);
  ers_state_e nxt;
  logic       good_nxt;
  logic       stop_req;

  assign stop_req = mode_we && (!mode_ers || !mode_start);
  assign load     = (state == ST_ARM) && mode_we && mode_ers && mode_start;

  always_comb begin
    nxt      = state;
    good_nxt = good;
    unique case (state)
      ST_IDLE: if (mode_we && mode_ers) nxt = ST_SEL;
      ST_SEL: begin
        if (mode_we && !mode_ers) nxt = ST_IDLE;
        else if (ilk_we)          nxt = ST_ARM;
      end
      ST_ARM: begin
        if (mode_we && !mode_ers) nxt = ST_IDLE;
        else if (load) begin
          if (cand_empty) begin
            nxt      = ST_DONE;
            good_nxt = 1'b1;
          end else begin
            nxt      = ST_RUN;
            good_nxt = 1'b0;
          end
        end
      end
      ST_RUN: begin
        if (stop_req) begin
          nxt      = ST_DONE;
          good_nxt = 1'b0;
        end else if (run_last) begin
          nxt      = ST_DONE;
          good_nxt = 1'b1;
        end
      end
      ST_DONE: begin
        if (mode_we && !mode_ers)        nxt = ST_IDLE;
        else if (mode_we && !mode_start) nxt = ST_SEL;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      good     <= 1'b0;
      shadow_q <= 1'b0;
    end else begin
      state <= nxt;
      good  <= good_nxt;
      if (state == ST_SEL && ilk_we && !(mode_we && !mode_ers))
        shadow_q <= ilk_shadow;
    end
  end

  assign done = (state == ST_DONE);
endmodule

// File: rtl/ers_target.sv
module ers_target #(
  parameter int NB    = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB:0]      sel_q,
  input  logic [NB:0]      lock_q,
  input  logic             shadow_q,
  input  logic             load,
  input  logic             blk_done,
  output logic             cand_empty,
  output logic             mask_any,
  output logic             rest_empty,
  output logic [IDX_W-1:0] pick
);
  // Mask bit i < NB: ordinary block i; bit NB: shadow block.
  // The test block has no bit here, so it can never be chosen.
  logic [NB:0] cand;
  logic [NB:0] mask_q;
  logic [NB:0] pick_oh;

  for (genvar i = 0; i < NB; i++) begin : g_norm
    assign cand[i] = !shadow_q && sel_q[i] && !lock_q[i];
  end
  assign cand[NB] = shadow_q && !lock_q[NB];

  assign cand_empty = (cand == '0);
  assign mask_any   = (mask_q != '0);

  // Lowest set bit wins.
  always_comb begin
    pick    = '0;
    pick_oh = '0;
    for (int i = NB; i >= 0; i--) begin
      if (mask_q[i]) begin
        pick    = IDX_W'(i);
        pick_oh = (NB+1)'(1) << i;
      end
    end
  end

  assign rest_empty = ((mask_q & ~pick_oh) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (load)     mask_q <= cand;
    else if (blk_done) mask_q <= mask_q & ~pick_oh;
  end
endmodule

// File: rtl/ers_stream.sv
module ers_stream #(
  parameter int WPB    = 4,
  parameter int WORD_W = 2,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              halt,
  input  logic              load,
  input  logic              mask_any,
  input  logic [IDX_W-1:0]  pick,
  input  logic              ready,
  output logic              valid,
  output logic [IDX_W-1:0]  blk,
  output logic [WORD_W-1:0] word,
  output logic [DATA_W-1:0] data,
  output logic              blk_done
);
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WPB - 1);

  logic [WORD_W-1:0] word_q;
  logic              beat;

  assign valid    = run && mask_any;
  assign blk      = pick;
  assign word     = word_q;
  assign data     = '1;
  assign beat     = valid && ready && !halt;
  assign blk_done = beat && (word_q == LAST_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (load)     word_q <= '0;
    else if (blk_done) word_q <= '0;
    else if (beat)     word_q <= word_q + 1'b1;
  end
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_pkg::*;
#(
  parameter int N_LOW         = 2,
  parameter int N_MID         = 2,
  parameter int N_HIGH        = 4,
  parameter int WORDS_PER_BLK = 4,
  parameter int DATA_W        = 32,
  localparam int NB     = N_LOW + N_MID + N_HIGH,
  localparam int IDX_W  = $clog2(NB + 2),
  localparam int WORD_W = (WORDS_PER_BLK > 1) ? $clog2(WORDS_PER_BLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              mode_ers,
  input  logic              mode_start,
  input  logic              sel_we,
  input  logic [NB:0]       sel_data,
  input  logic              lock_we,
  input  logic [NB:0]       lock_data,
  input  logic              ilk_we,
  input  logic              ilk_shadow,
  output logic              done,
  output logic              good,
  output logic              ers_valid,
  input  logic              ers_ready,
  output logic [IDX_W-1:0]  ers_blk,
  output logic [WORD_W-1:0] ers_word,
  output logic [DATA_W-1:0] ers_data
);
  ers_state_e       state;
  logic             shadow_q;
  logic             load;
  logic             running;
  logic             halt;
  logic [NB:0]      sel_q;
  logic [NB:0]      lock_q;
  logic             cand_empty;
  logic             mask_any;
  logic             rest_empty;
  logic [IDX_W-1:0] pick;
  logic             blk_done;
  logic             run_last;

  assign running  = (state == ST_RUN);
  assign halt     = mode_we && (!mode_ers || !mode_start);
  assign run_last = blk_done && rest_empty;

  ers_regs #(.NBITS(NB + 1)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ok(!running),
    .sel_we(sel_we), .sel_data(sel_data),
    .lock_we(lock_we), .lock_data(lock_data),
    .sel_q(sel_q), .lock_q(lock_q)
  );

  ers_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_ers(mode_ers), .mode_start(mode_start),
    .ilk_we(ilk_we), .ilk_shadow(ilk_shadow),
    .cand_empty(cand_empty), .run_last(run_last),
    .state(state), .shadow_q(shadow_q), .load(load),
    .done(done), .good(good)
  );

  ers_target #(.NB(NB), .IDX_W(IDX_W)) u_target (
    .clk(clk), .rst_n(rst_n),
    .sel_q(sel_q), .lock_q(lock_q), .shadow_q(shadow_q),
    .load(load), .blk_done(blk_done),
    .cand_empty(cand_empty), .mask_any(mask_any),
    .rest_empty(rest_empty), .pick(pick)
  );

  ers_stream #(
    .WPB(WORDS_PER_BLK), .WORD_W(WORD_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_stream (
    .clk(clk), .rst_n(rst_n),
    .run(running), .halt(halt), .load(load),
    .mask_any(mask_any), .pick(pick), .ready(ers_ready),
    .valid(ers_valid), .blk(ers_blk), .word(ers_word), .data(ers_data),
    .blk_done(blk_done)
  );
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
  parameter int NB     = 8,
  parameter int IDX_W  = 4,
  parameter int WORD_W = 2,
  parameter int DATA_W = 32,
  parameter int WPB    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_we,
  input logic              mode_ers,
  input logic              mode_start,
  input logic              running,
  input logic [NB:0]       lock_q,
  input logic              done,
  input logic              good,
  input logic              ers_valid,
  input logic              ers_ready,
  input logic [IDX_W-1:0]  ers_blk,
  input logic [WORD_W-1:0] ers_word,
  input logic [DATA_W-1:0] ers_data
);
  logic stopw;
  assign stopw = mode_we && (!mode_ers || !mode_start);

  AST_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ers_valid |-> (ers_data == {DATA_W{1'b1}})); // R1

  AST_NO_TEST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ers_valid |-> (ers_blk != IDX_W'(NB + 1))); // R4

  AST_LOCKED_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_valid && (ers_blk <= IDX_W'(NB))) |-> !lock_q[ers_blk]); // R3

  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && stopw) |=> (done && !good && !ers_valid)); // R7

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_valid && !ers_ready && !stopw) |=>
      (ers_valid && $stable(ers_blk) && $stable(ers_word))); // R11

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_valid && ers_ready && !stopw && ers_word == WORD_W'(WPB - 1)) |=>
      (!ers_valid || ers_blk > $past(ers_blk))); // R8

  AST_VALID_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ers_valid |-> (running && !done)); // R2
endmodule

bind erase_seq erase_seq_chk #(
  .NB(NB), .IDX_W(IDX_W), .WORD_W(WORD_W), .DATA_W(DATA_W), .WPB(WORDS_PER_BLK)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mode_we(mode_we), .mode_ers(mode_ers), .mode_start(mode_start),
  .running(running), .lock_q(lock_q),
  .done(done), .good(good),
  .ers_valid(ers_valid), .ers_ready(ers_ready),
  .ers_blk(ers_blk), .ers_word(ers_word), .ers_data(ers_data)
);

// File: tb/tb_erase_seq.sv
module tb_erase_seq;
  localparam int NL = 1, NM = 2, NH = 3, WPB = 3, DW = 16;
  localparam int NB = NL + NM + NH;
  localparam int IW = $clog2(NB + 2);
  localparam int WW = $clog2(WPB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 0, mode_ers = 0, mode_start = 0;
  logic sel_we = 0, lock_we = 0, ilk_we = 0, ilk_shadow = 0;
  logic [NB:0] sel_data = '0, lock_data = '0;
  logic done, good, ers_valid;
  logic ers_ready = 1'b1;
  logic [IW-1:0] ers_blk;
  logic [WW-1:0] ers_word;
  logic [DW-1:0] ers_data;

  int checks = 0, fails = 0;
  int exp_q[$];
  bit bp_mode = 0;
  bit abort_seen = 0;
  int bp_cnt = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  erase_seq #(.N_LOW(NL), .N_MID(NM), .N_HIGH(NH), .WORDS_PER_BLK(WPB), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_ers(mode_ers), .mode_start(mode_start),
    .sel_we(sel_we), .sel_data(sel_data),
    .lock_we(lock_we), .lock_data(lock_data),
    .ilk_we(ilk_we), .ilk_shadow(ilk_shadow),
    .done(done), .good(good),
    .ers_valid(ers_valid), .ers_ready(ers_ready),
    .ers_blk(ers_blk), .ers_word(ers_word), .ers_data(ers_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // ready driver, away from both edges
  always @(posedge clk) begin
    #2;
    ers_ready = bp_mode ? ((bp_cnt % 3) != 1) : 1'b1;
    bp_cnt++;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "WATCHDOG", cyc, 100000);
      finish_run();
    end
  end

  // monitor: scoreboard pop and back-pressure hold check
  bit hold_pend = 0;
  int hold_b = 0, hold_w = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend && !abort_seen) begin
        chk(ers_valid && int'(ers_blk) == hold_b && int'(ers_word) == hold_w,
            "R11 beat held under stall", int'(ers_blk) * 64 + int'(ers_word), hold_b * 64 + hold_w);
      end
      hold_pend = ers_valid && !ers_ready;
      hold_b = int'(ers_blk);
      hold_w = int'(ers_word);
      if (ers_valid && ers_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3/R4/R5 unexpected beat", int'(ers_blk) * 64 + int'(ers_word), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(ers_blk) * 64 + int'(ers_word) == e, "R8 beat order",
              int'(ers_blk) * 64 + int'(ers_word), e);
          chk(ers_data == {DW{1'b1}}, "R1 all-ones data", int'(ers_data), 32'h0000FFFF);
        end
      end
    end
  end

  task automatic pulse_mode(input bit e, input bit s);
    @(negedge clk); mode_we = 1; mode_ers = e; mode_start = s;
    @(negedge clk); mode_we = 0;
  endtask
  task automatic pulse_sel(input logic [NB:0] v);
    @(negedge clk); sel_we = 1; sel_data = v;
    @(negedge clk); sel_we = 0;
  endtask
  task automatic pulse_lock(input logic [NB:0] v);
    @(negedge clk); lock_we = 1; lock_data = v;
    @(negedge clk); lock_we = 0;
  endtask
  task automatic pulse_ilk(input bit sh);
    @(negedge clk); ilk_we = 1; ilk_shadow = sh;
    @(negedge clk); ilk_we = 0;
  endtask

  // driver side of the scoreboard: expected beats from the requirements
  task automatic push_expected(input logic [NB:0] sel, input logic [NB:0] lock, input bit sh);
    if (sh) begin
      if (!lock[NB]) for (int w = 0; w < WPB; w++) exp_q.push_back(NB * 64 + w);
    end else begin
      for (int b = 0; b < NB; b++)
        if (sel[b] && !lock[b])
          for (int w = 0; w < WPB; w++) exp_q.push_back(b * 64 + w);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic full_erase(input logic [NB:0] sel, input logic [NB:0] lock, input bit sh,
                            input string req);
    pulse_mode(1, 0);
    pulse_sel(sel);
    pulse_lock(lock);
    pulse_ilk(sh);
    push_expected(sel, lock, sh);
    pulse_mode(1, 1);
    wait_done();
    chk(done == 1'b1, {req, " done"}, done, 1);
    chk(good == 1'b1, {req, " good"}, good, 1);
    chk(exp_q.size() == 0, {req, " all beats seen"}, exp_q.size(), 0);
    pulse_mode(0, 0);
    chk(done == 1'b0, "R13 done cleared", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(done == 0 && good == 0 && ers_valid == 0, "R12 reset outputs",
        {done, good, ers_valid}, 0);

    // R12 masks start cleared: erase with no select writes finishes empty
    pulse_mode(1, 0);
    pulse_ilk(0);
    pulse_mode(1, 1);
    chk(done == 1 && good == 1, "R12 masks zero after reset", {done, good}, 3);
    pulse_mode(0, 0);

    // R1 R8 basic walk
    full_erase(7'b0001011, 7'b0000000, 0, "R8 basic");
    // R3 locked blocks skipped
    full_erase(7'b0111100, 7'b0010100, 0, "R3 lock");
    // R4 test block select bit ignored
    full_erase(7'b1000001, 7'b0000000, 0, "R4 test");
    // R5 shadow only, select ignored
    full_erase(7'b0111111, 7'b0000000, 1, "R5 shadow");

    // R5 R9 locked shadow: nothing to do
    pulse_mode(1, 0);
    pulse_lock(7'b1000000);
    pulse_ilk(1);
    pulse_mode(1, 1);
    chk(done == 1 && good == 1, "R5 R9 locked shadow completes at once", {done, good}, 3);
    pulse_mode(0, 0);
    pulse_lock(7'b0);

    // R9 empty selection
    pulse_mode(1, 0);
    pulse_sel(7'b0);
    pulse_ilk(0);
    pulse_mode(1, 1);
    chk(done == 1 && good == 1, "R9 empty completes next cycle", {done, good}, 3);
    chk(ers_valid == 0, "R9 no beats", ers_valid, 0);

    // R13 back to selection, start without new interlock ignored
    pulse_mode(1, 0);
    chk(done == 0, "R13 done drops on start clear", done, 0);
    pulse_sel(7'b0000001);
    pulse_mode(1, 1);
    repeat (4) @(negedge clk);
    chk(done == 0 && ers_valid == 0, "R13 R2 start needs new interlock", {done, ers_valid}, 0);
    pulse_mode(0, 0);

    // R2 start before interlock ignored, then proper launch runs
    pulse_mode(1, 0);
    pulse_sel(7'b0000100);
    pulse_mode(1, 1);
    repeat (3) @(negedge clk);
    chk(done == 0 && ers_valid == 0, "R2 early start ignored", {done, ers_valid}, 0);
    pulse_ilk(0);
    push_expected(7'b0000100, 7'b0, 0);
    pulse_mode(1, 1);
    wait_done();
    chk(good == 1 && exp_q.size() == 0, "R2 launch after interlock", exp_q.size(), 0);
    pulse_mode(0, 0);

    // R6 terminate without starting
    pulse_mode(1, 0);
    pulse_sel(7'b0111111);
    pulse_ilk(0);
    pulse_mode(0, 0);
    repeat (5) @(negedge clk);
    chk(done == 0 && ers_valid == 0, "R6 terminated session idle", {done, ers_valid}, 0);
    pulse_mode(1, 1);
    repeat (3) @(negedge clk);
    chk(done == 0 && ers_valid == 0, "R6 start after terminate ignored", {done, ers_valid}, 0);
    pulse_mode(0, 0);

    // R7 abort mid-walk
    pulse_mode(1, 0);
    pulse_sel(7'b0111111);
    pulse_ilk(0);
    push_expected(7'b0111111, 7'b0, 0);
    pulse_mode(1, 1);
    repeat (4) @(negedge clk);
    abort_seen = 1;
    pulse_mode(1, 0);
    chk(done == 1 && good == 0 && ers_valid == 0, "R7 abort flags",
        {done, good, ers_valid}, 4);
    chk(exp_q.size() > 0, "R7 walk cut short", exp_q.size(), 1);
    exp_q.delete();
    pulse_mode(0, 0);
    abort_seen = 0;

    // R10 R11 back-pressure with mask writes during the walk
    bp_mode = 1;
    pulse_mode(1, 0);
    pulse_sel(7'b0101010);
    pulse_lock(7'b0);
    pulse_ilk(0);
    push_expected(7'b0101010, 7'b0, 0);
    pulse_mode(1, 1);
    repeat (2) @(negedge clk);
    pulse_lock(7'b1111111);
    pulse_sel(7'b0111111);
    wait_done();
    chk(good == 1 && exp_q.size() == 0, "R10 mask writes ignored in run", exp_q.size(), 0);
    pulse_mode(0, 0);
    bp_mode = 0;
    // lock stayed zero: block 0 still erasable
    full_erase(7'b0000001, 7'b0, 0, "R10 lock unchanged");

    finish_run();
  end
endmodule